// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two 8-bit ports, A and B, through a transceiver that can forward either live data or held data. Each port owns a holding register with its own clock, and that register samples the port's incoming value on every rising edge of that clock. It does so whatever the transfer controls are set to. An active-low transfer enable and a direction bit decide which port, if any, the block drives. Two per-direction source selects decide whether the driven port receives the other port's live input or that port's held register.

Each port is split into an input bus, an output bus and an output-enable. The enclosing pad or bus logic turns these into a shared wire, so the block itself has no tristate nets. When the transfer enable is high, the block is isolated and drives neither port. Both registers can still be loaded in isolation, so data can be parked and forwarded later. All paths are non-inverting. A synchronous active-high reset clears each register on an edge of that register's own clock.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_a` with `rst` low, the A holding register takes the value of `a_in`, whatever the values of `xfer_en_n`, `to_b`, `ab_use_reg` and `ba_use_reg`.
- R2: On every rising edge of `clk_b` with `rst` low, the B holding register takes the value of `b_in`, whatever the values of the transfer controls.
- R3: A rising edge of `clk_a` with `rst` high clears the A register to zero. A rising edge of `clk_b` with `rst` high clears the B register to zero.
- R4: While `xfer_en_n` is 1, `a_oe` and `b_oe` are both 0, whatever `to_b`, `ab_use_reg` and `ba_use_reg` are.
- R5: While `xfer_en_n` is 0 and `to_b` is 1, `b_oe` is 1 and `a_oe` is 0.
- R6: While `xfer_en_n` is 0 and `to_b` is 0, `a_oe` is 1 and `b_oe` is 0.
- R7: While `b_oe` is 1, `b_out` equals `a_in` if `ab_use_reg` is 0, and equals the A register if `ab_use_reg` is 1. The value is not inverted.
- R8: While `a_oe` is 1, `a_out` equals `b_in` if `ba_use_reg` is 0, and equals the B register if `ba_use_reg` is 1. The value is not inverted.
- R9: In stored mode, a rising edge on the source port's clock updates the driven port's output to the newly captured value, with no further edge needed.
- R10: A port whose output-enable is 0 presents all zeros on its output bus.
- R11: At no time are `a_oe` and `b_oe` both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Capture clock for the A holding register |
| clk_b | input | 1 | Capture clock for the B holding register |
| rst | input | 1 | Synchronous active-high clear, seen by each register on its own clock |
| xfer_en_n | input | 1 | Active-low transfer enable; 1 isolates both ports |
| to_b | input | 1 | Direction: 1 drives port B, 0 drives port A |
| ab_use_reg | input | 1 | Source for B: 0 live `a_in`, 1 A register |
| ba_use_reg | input | 1 | Source for A: 0 live `b_in`, 1 B register |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | Value the block drives onto port A |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | Value the block drives onto port B |
| b_oe | output | 1 | Drive enable for port B |

## Verification
The hardest case to reach is showing that a register was loaded while its own port was driven, or while the block was isolated. Neither register can be seen directly, and its contents only appear on the far port in stored mode. The bench therefore loads both registers under every control combination. It then changes the live inputs to different values before it looks at the outputs, so a stored value can never be mistaken for a live one. To show that the captured value is forwarded at once (R9), the bench changes the source input right after the clock edge, and the driven port must still show the value held at the edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        DRIVE_NONE = 2'd0,
        DRIVE_A    = 2'd1,
        DRIVE_B    = 2'd2
    } drive_e;

    typedef struct packed {
        logic a_oe;
        logic b_oe;
        src_e a_src;
        src_e b_src;
    } route_t;

    function automatic drive_e pick_target(input logic en_n, input logic dir_b);
        if (en_n)
            return DRIVE_NONE;
        return dir_b ? DRIVE_B : DRIVE_A;
    endfunction

    function automatic src_e pick_source(input logic use_reg);
        return use_reg ? SRC_STORED : SRC_LIVE;
    endfunction

endpackage

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/xcvr_route_decode.sv
module xcvr_route_decode
    import xcvr_pkg::*;
(
    input  logic   en_n,
    input  logic   dir_b,
    input  logic   ab_use_reg,
    input  logic   ba_use_reg,
    output route_t route
);
    drive_e target;

    always_comb begin
        target      = pick_target(en_n, dir_b);
        route.a_oe  = (target == DRIVE_A);
        route.b_oe  = (target == DRIVE_B);
        route.a_src = pick_source(ba_use_reg);
        route.b_src = pick_source(ab_use_reg);
    end
endmodule

// File: rtl/xcvr_port_drive.sv
module xcvr_port_drive
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             oe,
    input  src_e             src,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] stored,
    output logic [WIDTH-1:0] out
);
    always_comb begin
        if (!oe)
            out = '0;
        else if (src == SRC_STORED)
            out = stored;
        else
            out = live;
    end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst,
    input  logic             xfer_en_n,
    input  logic             to_b,
    input  logic             ab_use_reg,
    input  logic             ba_use_reg,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    localparam int NPORT = 2;
    localparam int PA    = 0;
    localparam int PB    = 1;

    logic [NPORT-1:0]  port_clk;
    logic [WIDTH-1:0]  port_in  [NPORT];
    logic [WIDTH-1:0]  hold_q   [NPORT];
    logic [WIDTH-1:0]  reg_a_q;
    logic [WIDTH-1:0]  reg_b_q;
    route_t            route;

    assign port_clk    = {clk_b, clk_a};
    assign port_in[PA] = a_in;
    assign port_in[PB] = b_in;

    // One holding register per port, each on its own clock, capture never gated
    for (genvar p = 0; p < NPORT; p++) begin : g_hold
        xcvr_hold_reg #(.WIDTH(WIDTH)) u_reg (
            .clk (port_clk[p]),
            .rst (rst),
            .d   (port_in[p]),
            .q   (hold_q[p])
        );
    end

    assign reg_a_q = hold_q[PA];
    assign reg_b_q = hold_q[PB];

    xcvr_route_decode u_decode (
        .en_n       (xfer_en_n),
        .dir_b      (to_b),
        .ab_use_reg (ab_use_reg),
        .ba_use_reg (ba_use_reg),
        .route      (route)
    );

    // Port A is fed from the B side, port B from the A side
    xcvr_port_drive #(.WIDTH(WIDTH)) u_drive_a (
        .oe     (route.a_oe),
        .src    (route.a_src),
        .live   (b_in),
        .stored (reg_b_q),
        .out    (a_out)
    );

    xcvr_port_drive #(.WIDTH(WIDTH)) u_drive_b (
        .oe     (route.b_oe),
        .src    (route.b_src),
        .live   (a_in),
        .stored (reg_a_q),
        .out    (b_out)
    );

    assign a_oe = route.a_oe;
    assign b_oe = route.b_oe;
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk_a,
    input logic             clk_b,
    input logic             rst,
    input logic             xfer_en_n,
    input logic             to_b,
    input logic             ab_use_reg,
    input logic             ba_use_reg,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             a_oe,
    input logic             b_oe,
    input logic [WIDTH-1:0] reg_a_q,
    input logic [WIDTH-1:0] reg_b_q
);
    a_r1_capture_a: assert property (@(posedge clk_a) disable iff (rst)
        1'b1 |=> reg_a_q == $past(a_in));

    a_r2_capture_b: assert property (@(posedge clk_b) disable iff (rst)
        1'b1 |=> reg_b_q == $past(b_in));

    a_r4_isolation: assert property (@(posedge clk_a) disable iff (rst)
        xfer_en_n |-> (!a_oe && !b_oe));

    a_r5_drive_b: assert property (@(posedge clk_a) disable iff (rst)
        (!xfer_en_n && to_b) |-> (b_oe && !a_oe));

    a_r6_drive_a: assert property (@(posedge clk_b) disable iff (rst)
        (!xfer_en_n && !to_b) |-> (a_oe && !b_oe));

    a_r7_b_source: assert property (@(posedge clk_a) disable iff (rst)
        b_oe |-> (b_out == (ab_use_reg ? reg_a_q : a_in)));

    a_r8_a_source: assert property (@(posedge clk_b) disable iff (rst)
        a_oe |-> (a_out == (ba_use_reg ? reg_b_q : b_in)));

    a_r10_idle_zero: assert property (@(posedge clk_a) disable iff (rst)
        (!a_oe |-> a_out == '0) and (!b_oe |-> b_out == '0));

    a_r11_one_driver: assert property (@(posedge clk_b) disable iff (rst)
        $onehot0({a_oe, b_oe}));
endmodule

bind dual_reg_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk_a      (clk_a),
    .clk_b      (clk_b),
    .rst        (rst),
    .xfer_en_n  (xfer_en_n),
    .to_b       (to_b),
    .ab_use_reg (ab_use_reg),
    .ba_use_reg (ba_use_reg),
    .a_in       (a_in),
    .b_in       (b_in),
    .a_out      (a_out),
    .b_out      (b_out),
    .a_oe       (a_oe),
    .b_oe       (b_oe),
    .reg_a_q    (reg_a_q),
    .reg_b_q    (reg_b_q)
);

// File: tb/tb_dual_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_reg_xcvr;
    localparam int W = 8;

    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic         rst = 1'b0;
    logic         xfer_en_n = 1'b1;
    logic         to_b = 1'b0;
    logic         ab_use_reg = 1'b0;
    logic         ba_use_reg = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [W-1:0] exp_ra = '0;
    logic [W-1:0] exp_rb = '0;

    dual_reg_xcvr #(.WIDTH(W)) dut (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst),
        .xfer_en_n(xfer_en_n), .to_b(to_b),
        .ab_use_reg(ab_use_reg), .ba_use_reg(ba_use_reg),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // One 10 ns pulse, i.e. the 100 MHz clock rate, on demand
    task automatic pulse_a();
        #5 clk_a = 1'b1;
        exp_ra = rst ? '0 : a_in;
        #5 clk_a = 1'b0;
    endtask

    task automatic pulse_b();
        #5 clk_b = 1'b1;
        exp_rb = rst ? '0 : b_in;
        #5 clk_b = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (en_n=%0b to_b=%0b ab=%0b ba=%0b)",
                     req, act, exp, xfer_en_n, to_b, ab_use_reg, ba_use_reg);
        end
    endtask

    // Full comparison of all outputs against the requirement model
    task automatic check_all();
        logic         e_aoe, e_boe;
        logic [W-1:0] e_aout, e_bout;
        string        oe_tag;
        #1;
        e_aoe  = !xfer_en_n && !to_b;
        e_boe  = !xfer_en_n && to_b;
        e_bout = e_boe ? (ab_use_reg ? exp_ra : a_in) : '0;
        e_aout = e_aoe ? (ba_use_reg ? exp_rb : b_in) : '0;
        oe_tag = xfer_en_n ? "R4 isolation" : (to_b ? "R5 drive B" : "R6 drive A");
        check({oe_tag, " a_oe"}, {31'd0, a_oe}, {31'd0, e_aoe});
        check({oe_tag, " b_oe"}, {31'd0, b_oe}, {31'd0, e_boe});
        check("R11 single driver", {31'd0, a_oe & b_oe}, 32'd0);
        if (e_boe)
            check(ab_use_reg ? "R7 stored A->B (R1 capture)" : "R7 live A->B",
                  {24'd0, b_out}, {24'd0, e_bout});
        else
            check("R10 B idle zero", {24'd0, b_out}, 32'd0);
        if (e_aoe)
            check(ba_use_reg ? "R8 stored B->A (R2 capture)" : "R8 live B->A",
                  {24'd0, a_out}, {24'd0, e_aout});
        else
            check("R10 A idle zero", {24'd0, a_out}, 32'd0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R3: reset clears both registers; read back through stored mode
        a_in = 8'hA5; b_in = 8'h3C;
        pulse_a(); pulse_b();
        rst = 1'b1;
        pulse_a(); pulse_b();
        rst = 1'b0;
        xfer_en_n = 1'b0; to_b = 1'b1; ab_use_reg = 1'b1; ba_use_reg = 1'b1;
        #1 check("R3 A register cleared", {24'd0, b_out}, 32'd0);
        to_b = 1'b0;
        #1 check("R3 B register cleared", {24'd0, a_out}, 32'd0);

        // Sweep: all 16 control settings x 8 data patterns.
        // Registers are loaded under the swept controls (R1, R2 ungated),
        // then live inputs move away before comparison.
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 8; d++) begin
                logic [W-1:0] va, vb;
                va = W'(d * 37 + c * 11 + 5);
                vb = ~W'(d * 53 + c * 7);
                {xfer_en_n, to_b, ab_use_reg, ba_use_reg} = 4'(c);
                a_in = va; b_in = vb;
                pulse_a();
                pulse_b();
                a_in = va ^ 8'h5A;
                b_in = vb ^ 8'hC3;
                check_all();
                a_in = 8'h00; b_in = 8'hFF;
                check_all();
            end
        end

        // R9: stored mode toward B follows a fresh A capture at once
        xfer_en_n = 1'b0; to_b = 1'b1; ab_use_reg = 1'b1;
        a_in = 8'h81;
        pulse_a();
        a_in = 8'h18;
        #1 check("R9 B follows new A capture", {24'd0, b_out}, 32'h81);
        a_in = 8'hE7;
        pulse_a();
        a_in = 8'h00;
        #1 check("R9 B follows second A capture", {24'd0, b_out}, 32'hE7);

        // R9: stored mode toward A follows a fresh B capture
        to_b = 1'b0; ba_use_reg = 1'b1;
        b_in = 8'h42;
        pulse_b();
        b_in = 8'h99;
        #1 check("R9 A follows new B capture", {24'd0, a_out}, 32'h42);

        // R1: capture while A itself is driven, then show it toward B
        to_b = 1'b0; a_in = 8'h6D;
        pulse_a();
        a_in = 8'h11; to_b = 1'b1;
        #1 check("R1 capture while A driven", {24'd0, b_out}, 32'h6D);

        // R2: capture while B is driven, then show it toward A
        to_b = 1'b1; b_in = 8'hD6;
        pulse_b();
        b_in = 8'h22; to_b = 1'b0;
        #1 check("R2 capture while B driven", {24'd0, a_out}, 32'hD6);

        // R4: isolation masks every output, then stored data reappears
        xfer_en_n = 1'b1;
        #1 check("R4 isolation A", {23'd0, a_oe, a_out}, 32'd0);
        check("R4 isolation B", {23'd0, b_oe, b_out}, 32'd0);
        xfer_en_n = 1'b0;
        #1 check("R8 stored survives isolation", {24'd0, a_out}, 32'hD6);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule